// File: doc/BRIEF.md
# Frequency-Domain Equalizer Bin Engine

This block is the per-bin arithmetic stage of one user's iterative frequency-domain equalizer and interference regenerator. Bins of a transform block stream in one per accepted beat, each carrying the input spectrum value X, a feed-forward coefficient C, a feedback coefficient B, the regenerated decision spectrum S and the channel bin H. For each bin it produces one signed fixed-point complex result. Depending on the operation selected for the block, that result is the linear equalizer output, the decision-feedback equalizer output, the matched-filter output, the regenerated interference of the user, or the input spectrum of the next serial-cancellation stage with that interference removed.

A block begins with a beat that carries the start marker. The operation code and the first-iteration flag are captured on that beat and hold for all BINS bins of the block, whatever the ports show later. A two-state controller tracks the block. ST_IDLE waits for a start beat. The transition START (an accepted beat with the start marker) processes bin 0 and moves to ST_STREAM. In ST_STREAM every accepted beat is processed. The transition WRAP (the beat for bin BINS-1) marks the output as last and returns to ST_IDLE. The transition DROP is taken by an accepted beat in ST_IDLE without the marker: the beat is consumed and discarded, and the state stays in ST_IDLE. Coefficients, transforms and channel estimates are produced elsewhere and only arrive on the ports.

Values are Q1.15 complex numbers. Each complex product is kept at full precision. The sum is then rounded once, half up, by adding 2^14 and shifting right arithmetically by 15, and saturated to the 16-bit range.

Top module: `fdeq_bin_engine`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Operation code 0 (linear) gives Y = X·C.
- R3: Operation code 1 (feedback) with the first-iteration flag low gives Y = X·C + B·S.
- R4: Operation code 1 with the first-iteration flag high ignores B and S, and gives Y = X·C.
- R5: Operation code 2 (matched filter) gives Y = X·conj(H). The B and S inputs have no effect.
- R6: Operation code 3 (regenerate) gives V = H·S.
- R7: Operation code 4 (cancel) gives X − H·S, with the product kept at full precision before the single rounding.
- R8: Results are rounded once, half up, at bit 15 and then saturated to [−32768, 32767]. For example, (−32768)·(−32768) in linear mode gives 32767.
- R9: out_last is 1 exactly on the result of the BINS-th bin of a block, counted from the start beat.
- R10: An accepted beat without the start marker while no block is open produces no output.
- R11: The operation code and the first-iteration flag captured on the start beat apply to the whole block. Changes on those ports during the block are ignored.
- R12: While out_valid is 1 and out_ready is 0, the output holds stable, and in_ready equals (not out_valid) or out_ready. Every accepted bin appears exactly once, in order.
- R13: Operation codes 5, 6 and 7 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_sop | input | 1 | Beat is bin 0 of a new block |
| in_op | input | 3 | Operation code, captured on the start beat |
| in_first | input | 1 | First equalization iteration flag, captured on the start beat |
| in_x_re | input | 16 | Input spectrum, real part |
| in_x_im | input | 16 | Input spectrum, imaginary part |
| in_c_re | input | 16 | Feed-forward coefficient, real |
| in_c_im | input | 16 | Feed-forward coefficient, imaginary |
| in_b_re | input | 16 | Feedback coefficient, real |
| in_b_im | input | 16 | Feedback coefficient, imaginary |
| in_s_re | input | 16 | Regenerated decision spectrum, real |
| in_s_im | input | 16 | Regenerated decision spectrum, imaginary |
| in_h_re | input | 16 | Channel bin, real |
| in_h_im | input | 16 | Channel bin, imaginary |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted downstream |
| out_last | output | 1 | Result is the last bin of its block |
| out_re | output | 16 | Result, real part |
| out_im | output | 16 | Result, imaginary part |

## Verification
Two cases are hard to reach from the ports. The first is mode capture under change: the operation port moves on every beat inside a block, while the output path also stalls. The stimulus changes the code on each non-start beat and drives out_ready randomly, so captured state and backpressure act at the same time. The second is saturation at each point of the arithmetic. Blocks are built from the extreme values −32768, 32767, −1, 0 and 1. This drives the largest products, two summed products and the cancel subtraction past full scale in both directions. A run of beats without the start marker in the idle state checks that discarded beats leave no output behind.

// File: rtl/fdeq_pkg.sv
package fdeq_pkg;

    typedef enum logic [2:0] {
        OP_LINEAR = 3'd0,
        OP_DFE    = 3'd1,
        OP_RAKE   = 3'd2,
        OP_REGEN  = 3'd3,
        OP_CANCEL = 3'd4
    } fdeq_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } fdeq_state_e;

endpackage

// File: rtl/fdeq_cmul.sv
module fdeq_cmul #(
    parameter int DW = 16,
    localparam int PW = 2 * DW + 1
) (
    input  logic                 en_i,
    input  logic                 conj_i,
    input  logic signed [DW-1:0] a_re_i,
    input  logic signed [DW-1:0] a_im_i,
    input  logic signed [DW-1:0] b_re_i,
    input  logic signed [DW-1:0] b_im_i,
    output logic signed [PW-1:0] p_re_o,
    output logic signed [PW-1:0] p_im_o
);
    logic signed [2*DW-1:0] rr, ii, ri, ir;

    always_comb begin
        rr = a_re_i * b_re_i;
        ii = a_im_i * b_im_i;
        ri = a_re_i * b_im_i;
        ir = a_im_i * b_re_i;
        if (!en_i) begin
            p_re_o = '0;
            p_im_o = '0;
        end else if (conj_i) begin
            p_re_o = PW'(rr) + PW'(ii);
            p_im_o = PW'(ir) - PW'(ri);
        end else begin
            p_re_o = PW'(rr) - PW'(ii);
            p_im_o = PW'(ri) + PW'(ir);
        end
    end
endmodule

// File: rtl/fdeq_round_sat.sv
module fdeq_round_sat #(
    parameter int AW   = 35,
    parameter int DW   = 16,
    parameter int FRAC = 15,
    localparam int SW  = AW - FRAC
) (
    input  logic signed [AW-1:0] acc_i,
    output logic signed [DW-1:0] val_o
);
    logic signed [AW-1:0] biased;
    logic        [SW-1:0] shifted;
    logic        [SW-DW:0] top_bits;

    always_comb begin
        biased   = acc_i + (AW'(1) <<< (FRAC - 1));
        shifted  = biased[AW-1:FRAC];
        top_bits = shifted[SW-1:DW-1];
        if ((top_bits == '0) || (top_bits == '1)) begin
            val_o = shifted[DW-1:0];
        end else if (shifted[SW-1]) begin
            val_o = {1'b1, {(DW-1){1'b0}}};
        end else begin
            val_o = {1'b0, {(DW-1){1'b1}}};
        end
    end
endmodule

// File: rtl/fdeq_ctrl.sv
module fdeq_ctrl
    import fdeq_pkg::*;
#(
    parameter int BINS = 256,
    localparam int CW  = (BINS > 1) ? $clog2(BINS) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat_i,
    input  logic       sop_i,
    input  logic [2:0] op_i,
    input  logic       first_i,
    output logic       take_o,
    output logic       last_o,
    output logic [2:0] op_o,
    output logic       first_o
);
    fdeq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [2:0]    op_q, op_d;
    logic          first_q, first_d;
    logic          at_end;

    assign at_end = (cnt_q == CW'(BINS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            op_q    <= op_d;
            first_q <= first_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        op_d    = op_q;
        first_d = first_q;
        take_o  = 1'b0;
        last_o  = 1'b0;
        op_o    = op_q;
        first_o = first_q;
        unique case (state_q)
            ST_IDLE: begin
                op_o    = op_i;
                first_o = first_i;
                if (beat_i && sop_i) begin
                    take_o  = 1'b1;
                    op_d    = op_i;
                    first_d = first_i;
                    cnt_d   = CW'(1);
                    state_d = ST_STREAM;
                end
            end
            ST_STREAM: begin
                last_o = at_end;
                if (beat_i) begin
                    take_o = 1'b1;
                    if (at_end) begin
                        cnt_d   = '0;
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_BLOCK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && beat_i && at_end) |=> (state_q == ST_IDLE)); // R9

    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && beat_i && !sop_i) |=> (state_q == ST_IDLE)); // R10

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && $past(state_q == ST_STREAM)) |-> ($stable(op_q) && $stable(first_q))); // R11
endmodule

// File: rtl/fdeq_bin_engine.sv
module fdeq_bin_engine
    import fdeq_pkg::*;
#(
    parameter int BINS = 256,
    parameter int DW   = 16,
    localparam int FRAC = DW - 1,
    localparam int PW   = 2 * DW + 1,
    localparam int AW   = 2 * DW + 3,
    localparam int LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_sop,
    input  logic [2:0]           in_op,
    input  logic                 in_first,
    input  logic signed [DW-1:0] in_x_re,
    input  logic signed [DW-1:0] in_x_im,
    input  logic signed [DW-1:0] in_c_re,
    input  logic signed [DW-1:0] in_c_im,
    input  logic signed [DW-1:0] in_b_re,
    input  logic signed [DW-1:0] in_b_im,
    input  logic signed [DW-1:0] in_s_re,
    input  logic signed [DW-1:0] in_s_im,
    input  logic signed [DW-1:0] in_h_re,
    input  logic signed [DW-1:0] in_h_im,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_last,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);
    logic       beat, take, last_bin, eff_first;
    logic [2:0] eff_op;

    logic signed [DW-1:0] opa_re [LANES];
    logic signed [DW-1:0] opa_im [LANES];
    logic signed [DW-1:0] opb_re [LANES];
    logic signed [DW-1:0] opb_im [LANES];
    logic                 lane_en   [LANES];
    logic                 lane_conj [LANES];
    logic signed [PW-1:0] prod_re [LANES];
    logic signed [PW-1:0] prod_im [LANES];

    logic                 neg0, add_x;
    logic signed [AW-1:0] acc [2];
    logic signed [DW-1:0] res [2];

    assign in_ready = !out_valid || out_ready;
    assign beat     = in_valid && in_ready;

    fdeq_ctrl #(.BINS(BINS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat_i  (beat),
        .sop_i   (in_sop),
        .op_i    (in_op),
        .first_i (in_first),
        .take_o  (take),
        .last_o  (last_bin),
        .op_o    (eff_op),
        .first_o (eff_first)
    );

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            opa_re[l]    = '0;
            opa_im[l]    = '0;
            opb_re[l]    = '0;
            opb_im[l]    = '0;
            lane_en[l]   = 1'b0;
            lane_conj[l] = 1'b0;
        end
        neg0  = 1'b0;
        add_x = 1'b0;
        case (eff_op)
            OP_LINEAR, OP_DFE, OP_RAKE: begin
                opa_re[0]  = in_x_re;
                opa_im[0]  = in_x_im;
                lane_en[0] = 1'b1;
                if (eff_op == OP_RAKE) begin
                    opb_re[0]    = in_h_re;
                    opb_im[0]    = in_h_im;
                    lane_conj[0] = 1'b1;
                end else begin
                    opb_re[0] = in_c_re;
                    opb_im[0] = in_c_im;
                end
                if (eff_op == OP_DFE && !eff_first) begin
                    opa_re[1]  = in_b_re;
                    opa_im[1]  = in_b_im;
                    opb_re[1]  = in_s_re;
                    opb_im[1]  = in_s_im;
                    lane_en[1] = 1'b1;
                end
            end
            OP_REGEN, OP_CANCEL: begin
                opa_re[0]  = in_h_re;
                opa_im[0]  = in_h_im;
                opb_re[0]  = in_s_re;
                opb_im[0]  = in_s_im;
                lane_en[0] = 1'b1;
                neg0       = (eff_op == OP_CANCEL);
                add_x      = (eff_op == OP_CANCEL);
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fdeq_cmul #(.DW(DW)) u_cmul (
            .en_i   (lane_en[g]),
            .conj_i (lane_conj[g]),
            .a_re_i (opa_re[g]),
            .a_im_i (opa_im[g]),
            .b_re_i (opb_re[g]),
            .b_im_i (opb_im[g]),
            .p_re_o (prod_re[g]),
            .p_im_o (prod_im[g])
        );
    end

    always_comb begin
        logic signed [AW-1:0] xr, xi, p0r, p0i;
        xr  = add_x ? (AW'(in_x_re) <<< FRAC) : '0;
        xi  = add_x ? (AW'(in_x_im) <<< FRAC) : '0;
        p0r = neg0 ? -AW'(prod_re[0]) : AW'(prod_re[0]);
        p0i = neg0 ? -AW'(prod_im[0]) : AW'(prod_im[0]);
        acc[0] = xr + p0r + AW'(prod_re[1]);
        acc[1] = xi + p0i + AW'(prod_im[1]);
    end

    for (genvar g = 0; g < 2; g++) begin : g_rs
        fdeq_round_sat #(.AW(AW), .DW(DW), .FRAC(FRAC)) u_rs (
            .acc_i (acc[g]),
            .val_o (res[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_last  <= last_bin;
            out_re    <= res[0];
            out_im    <= res[1];
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last))); // R12

    AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !take); // R12
endmodule

// File: tb/fdeq_bin_engine_test.sv
module fdeq_bin_engine_test;
    localparam int BINS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic in_valid = 1'b0, in_sop = 1'b0, in_first = 1'b0, out_ready = 1'b1;
    logic [2:0] in_op = '0;
    logic signed [15:0] in_x_re = '0, in_x_im = '0, in_c_re = '0, in_c_im = '0;
    logic signed [15:0] in_b_re = '0, in_b_im = '0, in_s_re = '0, in_s_im = '0;
    logic signed [15:0] in_h_re = '0, in_h_im = '0;
    logic in_ready, out_valid, out_last;
    logic signed [15:0] out_re, out_im;

    fdeq_bin_engine #(.BINS(BINS)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_op(in_op), .in_first(in_first),
        .in_x_re(in_x_re), .in_x_im(in_x_im), .in_c_re(in_c_re), .in_c_im(in_c_im),
        .in_b_re(in_b_re), .in_b_im(in_b_im), .in_s_re(in_s_re), .in_s_im(in_s_im),
        .in_h_re(in_h_re), .in_h_im(in_h_im), .out_valid(out_valid), .out_ready(out_ready),
        .out_last(out_last), .out_re(out_re), .out_im(out_im)
    );

    int n_checks = 0, n_err = 0;
    logic [32:0] exp_q[$];
    string tag_q[$];
    string force_tag = "";
    bit bp_on = 1'b0;
    bit m_idle = 1'b1;
    int m_cnt = 0;
    logic [2:0] m_op = '0;
    logic m_first = 1'b0;

    function automatic logic signed [15:0] rsat(longint a);
        longint t;
        t = (a + 64'sd16384) >>> 15;
        if (t > 32767) return 16'sh7fff;
        if (t < -32768) return 16'sh8000;
        return t[15:0];
    endfunction

    function automatic logic [31:0] ref_bin(logic [2:0] op, logic fi);
        longint xr = in_x_re, xi = in_x_im, cr = in_c_re, ci = in_c_im;
        longint br = in_b_re, bi = in_b_im, sr = in_s_re, si = in_s_im;
        longint hr = in_h_re, hi = in_h_im;
        longint ar = 0, ai = 0;
        case (op)
            3'd0: begin ar = xr*cr - xi*ci; ai = xr*ci + xi*cr; end
            3'd1: begin
                ar = xr*cr - xi*ci; ai = xr*ci + xi*cr;
                if (!fi) begin ar += br*sr - bi*si; ai += br*si + bi*sr; end
            end
            3'd2: begin ar = xr*hr + xi*hi; ai = xi*hr - xr*hi; end
            3'd3: begin ar = hr*sr - hi*si; ai = hr*si + hi*sr; end
            3'd4: begin ar = xr*32768 - (hr*sr - hi*si); ai = xi*32768 - (hr*si + hi*sr); end
            default: begin ar = 0; ai = 0; end
        endcase
        return {rsat(ar), rsat(ai)};
    endfunction

    function automatic string op_tag(logic [2:0] op, logic fi);
        case (op)
            3'd0: return "R2";
            3'd1: return fi ? "R4" : "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R13";
        endcase
    endfunction

    task automatic check(string tag, bit ok, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model of accepted beats and output comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_valid && in_ready) begin
                if (!(m_idle && !in_sop)) begin
                    logic lst;
                    if (m_idle) begin
                        m_op = in_op; m_first = in_first; m_idle = 1'b0; m_cnt = 0;
                    end
                    lst = (m_cnt == BINS - 1);
                    exp_q.push_back({lst, ref_bin(m_op, m_first)});
                    tag_q.push_back(force_tag != "" ? force_tag : op_tag(m_op, m_first));
                    m_cnt++;
                    if (lst) m_idle = 1'b1;
                end
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R10", 1'b0, {out_re, out_im}, 0);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {out_re, out_im} == e[31:0], {out_re, out_im}, e[31:0]);
                    check("R9", out_last == e[32], out_last, e[32]);
                end
            end
        end
    end

    // random downstream backpressure
    always @(posedge clk) begin
        #1;
        if (bp_on) out_ready <= ($urandom_range(0, 3) != 0);
        else out_ready <= 1'b1;
    end

    function automatic logic signed [15:0] pick(int kind);
        if (kind == 0) return 16'($urandom);
        case ($urandom_range(0, 4))
            0: return 16'sh8000;
            1: return 16'sh7fff;
            2: return -16'sd1;
            3: return 16'sd0;
            default: return 16'sd1;
        endcase
    endfunction

    task automatic beat(logic sop, logic [2:0] op, logic fi, int kind);
        in_sop = sop; in_op = op; in_first = fi;
        in_x_re = pick(kind); in_x_im = pick(kind); in_c_re = pick(kind); in_c_im = pick(kind);
        in_b_re = pick(kind); in_b_im = pick(kind); in_s_re = pick(kind); in_s_im = pick(kind);
        in_h_re = pick(kind); in_h_im = pick(kind);
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        if ($urandom_range(0, 5) == 0) begin @(posedge clk); #1; end
    endtask

    task automatic block(logic [2:0] op, logic fi, int kind, bit toggle);
        for (int i = 0; i < BINS; i++)
            beat(i == 0, (toggle && i > 0) ? 3'($urandom_range(0, 7)) : op, toggle && i > 0 ? ~fi : fi, kind);
    endtask

    task automatic drain();
        bp_on = 1'b0;
        repeat (6) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", out_valid == 1'b0, out_valid, 0);
        check("R1", in_ready == 1'b1, in_ready, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // each operation, random data
        for (int op = 0; op < 5; op++) begin
            block(3'(op), 1'b0, 0, 1'b0);
            block(3'(op), 1'b1, 0, 1'b0);
        end
        // undefined codes give zero
        block(3'd5, 1'b0, 0, 1'b0);
        block(3'd7, 1'b1, 0, 1'b0);

        // saturation corners
        force_tag = "R8";
        for (int op = 0; op < 5; op++) block(3'(op), 1'b0, 1, 1'b0);
        in_x_re = 16'sh8000; in_x_im = 0; in_c_re = 16'sh8000; in_c_im = 0;
        in_sop = 1'b1; in_op = 3'd0; in_first = 1'b0; in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        for (int i = 1; i < BINS; i++) beat(1'b0, 3'd0, 1'b0, 1);
        drain();
        force_tag = "";

        // beats with no open block are discarded
        for (int i = 0; i < 5; i++) beat(1'b0, 3'd0, 1'b0, 0);
        drain();
        check("R10", out_valid == 1'b0 && exp_q.size() == 0, out_valid, 0);

        // mode port moving inside a block, under backpressure
        force_tag = "R11";
        bp_on = 1'b1;
        for (int k = 0; k < 6; k++) block(3'($urandom_range(0, 4)), 1'($urandom_range(0, 1)), 0, 1'b1);
        force_tag = "";

        // mixed random traffic under backpressure
        for (int k = 0; k < 40; k++)
            block(3'($urandom_range(0, 4)), 1'($urandom_range(0, 1)), $urandom_range(0, 1), 1'b0);
        drain();
        check("R12", exp_q.size() == 0, exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule